// File: doc/BRIEF.md
# HDLC Receive Descriptor Status Engine

This block sits behind an HDLC deframer that has already hunted flags and removed stuffed bits. It receives whole data octets, a strobe for each closing flag together with the count of leftover bits that did not make up an octet, and the raw line bit stream, which it uses to spot abort runs. Each frame's payload is spread over a ring of up to eight receive descriptors held in internal registers. Every byte goes out through a plain byte-write port, addressed by descriptor index and byte offset.

Software arms a descriptor by writing its wrap and interrupt options, which also marks it ready. When the engine finishes with a descriptor, it records the first, last, overlength, odd-bit-count and abort status and the length, and clears the ready bit. It also pulses the frame-received or buffer-received event. If a frame runs past the programmed maximum length, the engine stops storing bytes but keeps counting them. The overlength status and the true octet count are reported only when the closing flag arrives. If data arrives while the target descriptor is not ready, the engine raises a busy event and drops the rest of that frame.

Top module: `hdlc_rxbd_engine`

## Requirements
- R1: After reset, every descriptor reads not ready with status 0 and length 0, and `wr_en`, `ev_frame`, `ev_buf` and `ev_busy` are low.
- R2: A software write to a descriptor (`bd_we`) sets its ready bit, loads wrap and interrupt from `bd_wrap` and `bd_intr`, and clears its status and length. Status reads as `bd_rstat` = {first, last, overlength, odd-bits, abort}, bit 4 down to bit 0.
- R3: Each stored octet appears on `wr_data` one cycle after it is accepted. `wr_addr` = {descriptor index, byte offset}, offsets run from 0, and at most `max_len` octets of one frame are written.
- R4: A closing flag during a frame closes the current descriptor with last=1 and length = the frame's octet count, clears its ready bit, and pulses `ev_frame` whatever the descriptor's interrupt bit is. An octet presented in the same cycle as a flag is dropped.
- R5: The first bit is set only on the descriptor that took the frame's first octet.
- R6: When a descriptor already holds `buf_size` bytes and another octet of the same frame arrives, that descriptor closes with last=0 and length=`buf_size`. The octet goes to offset 0 of the next descriptor. A frame that ends exactly at `buf_size` bytes closes as last in the same descriptor.
- R7: A frame longer than `max_len` closes on its flag with the overlength bit set and length = the true octet count.
- R8: The odd-bits status is set when `tail_bits` is nonzero at the closing flag.
- R9: Seven consecutive one bits on the line during a frame close the current descriptor with last=1, abort=1 and length = octets so far. This pulses `ev_buf` if the interrupt bit is set, and does not pulse `ev_frame`. A zero bit restarts the run, and runs of ones outside a frame change nothing.
- R10: After a descriptor with wrap set, or the highest-numbered descriptor, is used, the next frame data goes to descriptor 0.
- R11: A non-final close (fill or abort) pulses `ev_buf` only if the descriptor's interrupt bit is set.
- R12: An octet whose target descriptor is not ready gives a single `ev_busy` pulse. The rest of the frame is discarded with no writes and no status change, and its closing flag raises no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bd_we | input | 1 | Software descriptor arm strobe |
| bd_widx | input | IDX_W | Descriptor index to arm |
| bd_wrap | input | 1 | Wrap option for the armed descriptor |
| bd_intr | input | 1 | Interrupt option for the armed descriptor |
| bd_ridx | input | IDX_W | Descriptor index to read |
| bd_rready | output | 1 | Ready bit of the read descriptor |
| bd_rstat | output | 5 | Status of the read descriptor {first,last,overlength,odd-bits,abort} |
| bd_rlen | output | LEN_W | Length field of the read descriptor |
| max_len | input | LEN_W | Maximum stored octets per frame |
| buf_size | input | BUF_AW+1 | Bytes per descriptor buffer, at least 1 |
| oct_valid | input | 1 | Destuffed octet strobe |
| oct_data | input | 8 | Destuffed octet |
| flag_close | input | 1 | Closing flag strobe |
| tail_bits | input | 3 | Leftover bit count at the closing flag |
| line_valid | input | 1 | Raw line bit strobe |
| line_bit | input | 1 | Raw line bit value |
| wr_en | output | 1 | Payload byte write strobe |
| wr_addr | output | IDX_W+BUF_AW | Payload address {descriptor, offset} |
| wr_data | output | 8 | Payload byte |
| ev_frame | output | 1 | Frame-received event pulse |
| ev_buf | output | 1 | Buffer-received event pulse |
| ev_busy | output | 1 | Busy event pulse |

## Verification
The hardest case to reach is a frame that crosses a descriptor boundary, so that a non-final close, a fresh first-octet write and a suppressed buffer event all fall on the same edge. Interrupt options are mixed across consecutive descriptors, and the stimulus is timed against a small buffer size to make this happen. The abort path is just as hard, because the octet stream and the raw line bits are separate. The stimulus places the run of ones inside a frame already in progress, then repeats it while idle and splits it with a zero, so that only the in-frame run may close the descriptor.

// File: rtl/hdlc_rxbd_pkg.sv
package hdlc_rxbd_pkg;
   typedef struct packed {
      logic first;
      logic last;
      logic lg;
      logic odd;
      logic ab;
   } bd_stat_t;
   localparam int STAT_W = $bits(bd_stat_t);
endpackage

// File: rtl/hdlc_rxbd_abort.sv
module hdlc_rxbd_abort #(
   parameter int RUN = 7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_valid,
   input  logic bit_val,
   output logic abort_o
);
   localparam int CW = $clog2(RUN + 1);

   if (RUN < 2) begin : g_bad_run
      $error("abort run length must be at least 2");
   end

   logic [CW-1:0] run_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q <= '0;
      end else if (bit_valid) begin
         if (!bit_val)
            run_q <= '0;
         else if (run_q != CW'(RUN))
            run_q <= run_q + 1'b1;
      end
   end

   assign abort_o = bit_valid && bit_val && (run_q == CW'(RUN - 1));

   // R9
   abort_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort_o |=> !abort_o);
endmodule

// File: rtl/hdlc_rxbd_ring.sv
module hdlc_rxbd_ring
   import hdlc_rxbd_pkg::*;
#(
   parameter int NBD   = 8,
   parameter int LEN_W = 12,
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sw_we,
   input  logic [IDX_W-1:0] sw_idx,
   input  logic             sw_wrap,
   input  logic             sw_intr,
   input  logic             cl_en,
   input  logic [IDX_W-1:0] cl_idx,
   input  bd_stat_t         cl_stat,
   input  logic [LEN_W-1:0] cl_len,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_ready,
   output bd_stat_t         rd_stat,
   output logic [LEN_W-1:0] rd_len,
   output logic [NBD-1:0]   ready_vec,
   output logic [NBD-1:0]   wrap_vec,
   output logic [NBD-1:0]   intr_vec
);
   if (NBD < 1 || NBD > 8) begin : g_bad_nbd
      $error("descriptor ring must hold 1 to 8 entries");
   end

   bd_stat_t         stat_w [NBD];
   logic [LEN_W-1:0] len_w  [NBD];

   for (genvar g = 0; g < NBD; g++) begin : g_bd
      logic             rdy_r, wrp_r, irq_r;
      bd_stat_t         st_r;
      logic [LEN_W-1:0] ln_r;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            rdy_r <= 1'b0;
            wrp_r <= 1'b0;
            irq_r <= 1'b0;
            st_r  <= '0;
            ln_r  <= '0;
         end else if (cl_en && cl_idx == IDX_W'(g)) begin
            rdy_r <= 1'b0;
            st_r  <= cl_stat;
            ln_r  <= cl_len;
         end else if (sw_we && sw_idx == IDX_W'(g)) begin
            rdy_r <= 1'b1;
            wrp_r <= sw_wrap;
            irq_r <= sw_intr;
            st_r  <= '0;
            ln_r  <= '0;
         end
      end

      assign ready_vec[g] = rdy_r;
      assign wrap_vec[g]  = wrp_r;
      assign intr_vec[g]  = irq_r;
      assign stat_w[g]    = st_r;
      assign len_w[g]     = ln_r;
   end

   assign rd_ready = ready_vec[rd_idx];
   assign rd_stat  = stat_w[rd_idx];
   assign rd_len   = len_w[rd_idx];

   // R4
   close_clears_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cl_en |=> !ready_vec[$past(cl_idx)]);

   // R2
   arm_sets_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_we && !(cl_en && cl_idx == sw_idx)) |=> ready_vec[$past(sw_idx)]);
endmodule

// File: rtl/hdlc_rxbd_frame.sv
module hdlc_rxbd_frame
   import hdlc_rxbd_pkg::*;
#(
   parameter int NBD    = 8,
   parameter int IDX_W  = 3,
   parameter int BUF_AW = 4,
   parameter int LEN_W  = 12
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    oct_valid,
   input  logic [7:0]              oct_data,
   input  logic                    flag_close,
   input  logic [2:0]              tail_bits,
   input  logic                    abort_hit,
   input  logic [LEN_W-1:0]        max_len,
   input  logic [BUF_AW:0]         buf_size,
   input  logic [NBD-1:0]          ready_vec,
   input  logic [NBD-1:0]          wrap_vec,
   input  logic [NBD-1:0]          intr_vec,
   output logic                    cl_en,
   output logic [IDX_W-1:0]        cl_idx,
   output bd_stat_t                cl_stat,
   output logic [LEN_W-1:0]        cl_len,
   output logic                    wr_en,
   output logic [IDX_W+BUF_AW-1:0] wr_addr,
   output logic [7:0]              wr_data,
   output logic                    ev_frame,
   output logic                    ev_buf,
   output logic                    ev_busy
);
   localparam logic [LEN_W-1:0] CNT_MAX = '1;

   if (LEN_W < BUF_AW + 1) begin : g_bad_len
      $error("length field narrower than buffer size");
   end

   logic                 in_frame_q, disc_q, firstp_q;
   logic [IDX_W-1:0]     cur_q;
   logic [BUF_AW:0]      bcnt_q;
   logic [LEN_W-1:0]     fcnt_q;

   logic                 in_frame_n, disc_n, firstp_n;
   logic [IDX_W-1:0]     cur_n, idx_w;
   logic [BUF_AW:0]      bcnt_n, bc, bc_l;
   logic [LEN_W-1:0]     fcnt_n, fc;
   logic                 fp, dsc;
   logic                 we_d, evf_d, evb_d, evy_d;
   logic [IDX_W+BUF_AW-1:0] addr_d;

   logic [IDX_W-1:0] nxt_of [NBD];
   for (genvar g = 0; g < NBD; g++) begin : g_nxt
      if (g == NBD - 1) begin : g_top
         assign nxt_of[g] = '0;
      end else begin : g_mid
         assign nxt_of[g] = wrap_vec[g] ? '0 : IDX_W'(g + 1);
      end
   end

   always_comb begin
      in_frame_n = in_frame_q;
      disc_n     = disc_q;
      firstp_n   = firstp_q;
      cur_n      = cur_q;
      bcnt_n     = bcnt_q;
      fcnt_n     = fcnt_q;
      cl_en      = 1'b0;
      cl_idx     = cur_q;
      cl_stat    = '0;
      cl_len     = fcnt_q;
      we_d       = 1'b0;
      addr_d     = '0;
      evf_d      = 1'b0;
      evb_d      = 1'b0;
      evy_d      = 1'b0;
      fc         = in_frame_q ? fcnt_q : '0;
      bc         = in_frame_q ? bcnt_q : '0;
      fp         = in_frame_q ? firstp_q : 1'b1;
      dsc        = in_frame_q && disc_q;
      bc_l       = bc;
      idx_w      = cur_q;

      if (abort_hit && in_frame_q) begin
         if (!disc_q) begin
            cl_en         = 1'b1;
            cl_stat.first = firstp_q;
            cl_stat.last  = 1'b1;
            cl_stat.lg    = fcnt_q > max_len;
            cl_stat.ab    = 1'b1;
            evb_d         = intr_vec[cur_q];
            cur_n         = nxt_of[cur_q];
         end
         in_frame_n = 1'b0;
         disc_n     = 1'b0;
      end else if (flag_close && in_frame_q) begin
         if (!disc_q) begin
            cl_en         = 1'b1;
            cl_stat.first = firstp_q;
            cl_stat.last  = 1'b1;
            cl_stat.lg    = fcnt_q > max_len;
            cl_stat.odd   = tail_bits != 3'd0;
            evf_d         = 1'b1;
            cur_n         = nxt_of[cur_q];
         end
         in_frame_n = 1'b0;
         disc_n     = 1'b0;
      end else if (oct_valid && !flag_close) begin
         in_frame_n = 1'b1;
         fcnt_n     = fc;
         bcnt_n     = bc;
         firstp_n   = fp;
         disc_n     = dsc;
         if (!dsc) begin
            fcnt_n = (fc == CNT_MAX) ? fc : fc + 1'b1;
            if (fc < max_len) begin
               if (bc == buf_size) begin
                  cl_en         = 1'b1;
                  cl_stat.first = fp;
                  cl_len        = LEN_W'(buf_size);
                  evb_d         = intr_vec[cur_q];
                  idx_w         = nxt_of[cur_q];
                  bc_l          = '0;
                  firstp_n      = 1'b0;
               end
               cur_n = idx_w;
               if (ready_vec[idx_w]) begin
                  we_d   = 1'b1;
                  addr_d = {idx_w, bc_l[BUF_AW-1:0]};
                  bcnt_n = bc_l + 1'b1;
               end else begin
                  evy_d  = 1'b1;
                  disc_n = 1'b1;
                  bcnt_n = bc_l;
               end
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_frame_q <= 1'b0;
         disc_q     <= 1'b0;
         firstp_q   <= 1'b0;
         cur_q      <= '0;
         bcnt_q     <= '0;
         fcnt_q     <= '0;
         wr_en      <= 1'b0;
         wr_addr    <= '0;
         wr_data    <= '0;
         ev_frame   <= 1'b0;
         ev_buf     <= 1'b0;
         ev_busy    <= 1'b0;
      end else begin
         in_frame_q <= in_frame_n;
         disc_q     <= disc_n;
         firstp_q   <= firstp_n;
         cur_q      <= cur_n;
         bcnt_q     <= bcnt_n;
         fcnt_q     <= fcnt_n;
         wr_en      <= we_d;
         wr_addr    <= addr_d;
         wr_data    <= oct_data;
         ev_frame   <= evf_d;
         ev_buf     <= evb_d;
         ev_busy    <= evy_d;
      end
   end

   // R3
   store_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (fcnt_q <= max_len));

   // R12
   busy_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_busy |-> (disc_q && !wr_en));

   // R12
   event_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ev_frame, ev_busy}));

   // R4
   frame_event_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cl_en && cl_stat.last && !cl_stat.ab) |=> ev_frame);
endmodule

// File: rtl/hdlc_rxbd_engine.sv
module hdlc_rxbd_engine
   import hdlc_rxbd_pkg::*;
#(
   parameter int  NBD       = 8,
   parameter int  BUF_AW    = 4,
   parameter int  LEN_W     = 12,
   parameter int  ABORT_RUN = 7,
   localparam int IDX_W     = (NBD > 1) ? $clog2(NBD) : 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    bd_we,
   input  logic [IDX_W-1:0]        bd_widx,
   input  logic                    bd_wrap,
   input  logic                    bd_intr,
   input  logic [IDX_W-1:0]        bd_ridx,
   output logic                    bd_rready,
   output logic [STAT_W-1:0]       bd_rstat,
   output logic [LEN_W-1:0]        bd_rlen,
   input  logic [LEN_W-1:0]        max_len,
   input  logic [BUF_AW:0]         buf_size,
   input  logic                    oct_valid,
   input  logic [7:0]              oct_data,
   input  logic                    flag_close,
   input  logic [2:0]              tail_bits,
   input  logic                    line_valid,
   input  logic                    line_bit,
   output logic                    wr_en,
   output logic [IDX_W+BUF_AW-1:0] wr_addr,
   output logic [7:0]              wr_data,
   output logic                    ev_frame,
   output logic                    ev_buf,
   output logic                    ev_busy
);
   logic             abort_p;
   logic             cl_en;
   logic [IDX_W-1:0] cl_idx;
   bd_stat_t         cl_stat, rd_stat;
   logic [LEN_W-1:0] cl_len;
   logic [NBD-1:0]   ready_vec, wrap_vec, intr_vec;

   hdlc_rxbd_abort #(.RUN(ABORT_RUN)) abort_i (
      .clk(clk), .rst_n(rst_n), .bit_valid(line_valid), .bit_val(line_bit),
      .abort_o(abort_p));

   hdlc_rxbd_ring #(.NBD(NBD), .LEN_W(LEN_W), .IDX_W(IDX_W)) ring_i (
      .clk(clk), .rst_n(rst_n),
      .sw_we(bd_we), .sw_idx(bd_widx), .sw_wrap(bd_wrap), .sw_intr(bd_intr),
      .cl_en(cl_en), .cl_idx(cl_idx), .cl_stat(cl_stat), .cl_len(cl_len),
      .rd_idx(bd_ridx), .rd_ready(bd_rready), .rd_stat(rd_stat), .rd_len(bd_rlen),
      .ready_vec(ready_vec), .wrap_vec(wrap_vec), .intr_vec(intr_vec));

   hdlc_rxbd_frame #(.NBD(NBD), .IDX_W(IDX_W), .BUF_AW(BUF_AW), .LEN_W(LEN_W)) frame_i (
      .clk(clk), .rst_n(rst_n),
      .oct_valid(oct_valid), .oct_data(oct_data), .flag_close(flag_close),
      .tail_bits(tail_bits), .abort_hit(abort_p),
      .max_len(max_len), .buf_size(buf_size),
      .ready_vec(ready_vec), .wrap_vec(wrap_vec), .intr_vec(intr_vec),
      .cl_en(cl_en), .cl_idx(cl_idx), .cl_stat(cl_stat), .cl_len(cl_len),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .ev_frame(ev_frame), .ev_buf(ev_buf), .ev_busy(ev_busy));

   assign bd_rstat = rd_stat;
endmodule

// File: tb/hdlc_rxbd_engine_tb.sv
module hdlc_rxbd_engine_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bd_we = 1'b0;
   logic [2:0]  bd_widx = '0;
   logic        bd_wrap = 1'b0, bd_intr = 1'b0;
   logic [2:0]  bd_ridx = '0;
   logic        bd_rready;
   logic [4:0]  bd_rstat;
   logic [11:0] bd_rlen;
   logic [11:0] max_len = 12'd10;
   logic [4:0]  buf_size = 5'd16;
   logic        oct_valid = 1'b0;
   logic [7:0]  oct_data = '0;
   logic        flag_close = 1'b0;
   logic [2:0]  tail_bits = '0;
   logic        line_valid = 1'b0, line_bit = 1'b0;
   logic        wr_en;
   logic [6:0]  wr_addr;
   logic [7:0]  wr_data;
   logic        ev_frame, ev_buf, ev_busy;

   always #4 clk = ~clk;

   hdlc_rxbd_engine dut_i (
      .clk(clk), .rst_n(rst_n), .bd_we(bd_we), .bd_widx(bd_widx),
      .bd_wrap(bd_wrap), .bd_intr(bd_intr), .bd_ridx(bd_ridx),
      .bd_rready(bd_rready), .bd_rstat(bd_rstat), .bd_rlen(bd_rlen),
      .max_len(max_len), .buf_size(buf_size), .oct_valid(oct_valid),
      .oct_data(oct_data), .flag_close(flag_close), .tail_bits(tail_bits),
      .line_valid(line_valid), .line_bit(line_bit), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .ev_frame(ev_frame),
      .ev_buf(ev_buf), .ev_busy(ev_busy));

   int vec_cnt = 0, bad = 0;
   int n_wr = 0, n_evf = 0, n_evb = 0, n_evy = 0;
   int last_addr = 0, last_data = 0;
   bit done = 0;

   always @(negedge clk) begin
      if (wr_en) begin
         n_wr++;
         last_addr = int'(wr_addr);
         last_data = int'(wr_data);
      end
      if (ev_frame) n_evf++;
      if (ev_buf)   n_evb++;
      if (ev_busy)  n_evy++;
   end

   typedef struct packed {
      logic [7:0]  n;
      logic [2:0]  tail;
      logic [11:0] len;
      logic [4:0]  stat;
   } vec_t;

   localparam vec_t VEC [5] = '{
      '{8'd3,  3'd0, 12'd3,  5'b11000},
      '{8'd5,  3'd3, 12'd5,  5'b11010},
      '{8'd10, 3'd0, 12'd10, 5'b11000},
      '{8'd13, 3'd0, 12'd13, 5'b11100},
      '{8'd1,  3'd1, 12'd1,  5'b11010}
   };

   task automatic chk(input string req, input int act, input int exp);
      vec_cnt++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic chk_bd(input string req, input int i, input int erdy,
                         input int est, input int eln);
      bd_ridx = i[2:0];
      #1;
      chk({req, " ready"},  int'(bd_rready), erdy);
      chk({req, " status"}, int'(bd_rstat),  est);
      chk({req, " length"}, int'(bd_rlen),   eln);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic arm(input int i, input bit wrp, input bit irq);
      bd_we = 1'b1; bd_widx = i[2:0]; bd_wrap = wrp; bd_intr = irq;
      @(negedge clk);
      bd_we = 1'b0;
   endtask

   task automatic send_oct(input int d);
      oct_valid = 1'b1; oct_data = d[7:0];
      @(negedge clk);
      oct_valid = 1'b0;
   endtask

   task automatic send_flag(input int tb);
      flag_close = 1'b1; tail_bits = tb[2:0];
      @(negedge clk);
      flag_close = 1'b0; tail_bits = '0;
   endtask

   task automatic send_bits(input int cnt, input bit b);
      for (int k = 0; k < cnt; k++) begin
         line_valid = 1'b1; line_bit = b;
         @(negedge clk);
      end
      line_valid = 1'b0;
   endtask

   task automatic send_frame(input int n, input int tb);
      for (int k = 0; k < n; k++) send_oct(8'hA0 + k);
      send_flag(tb);
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         bad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad);
         $finish;
      end
   end

   initial begin
      int b_wr, b_evf, b_evb, b_evy, st, idx;
      @(negedge clk);
      do_reset();

      // R1: reset state
      for (int i = 0; i < 8; i++) chk_bd("R1 reset bd", i, 0, 0, 0);
      chk("R1 wr_en idle", int'(wr_en), 0);
      chk("R1 events idle", int'({ev_frame, ev_buf, ev_busy}), 0);

      // Table walk: R3 R4 R5 R7 R8, one descriptor per frame
      max_len = 12'd10; buf_size = 5'd16;
      for (int v = 0; v < 5; v++) begin
         int n, stored;
         n = int'(VEC[v].n);
         stored = (n < 10) ? n : 10;
         arm(v, 1'b0, 1'b0);
         b_wr = n_wr; b_evf = n_evf; b_evb = n_evb;
         send_frame(n, int'(VEC[v].tail));
         chk_bd("R4 R5 R7 R8 table bd", v, 0, int'(VEC[v].stat), int'(VEC[v].len));
         chk("R3 table stored count", n_wr - b_wr, stored);
         chk("R3 table last addr", last_addr, v * 16 + stored - 1);
         chk("R3 table last data", last_data, 8'hA0 + stored - 1);
         chk("R4 table frame event", n_evf - b_evf, 1);
         chk("R11 table no buf event", n_evb - b_evb, 0);
      end

      // R2: re-arming a closed descriptor clears it
      arm(0, 1'b0, 1'b1);
      chk_bd("R2 rearm bd0", 0, 1, 0, 0);

      // R6 R11 R5: frame over three descriptors of 4 bytes
      do_reset();
      max_len = 12'd40; buf_size = 5'd4;
      arm(0, 1'b0, 1'b1); arm(1, 1'b0, 1'b0); arm(2, 1'b0, 1'b1); arm(3, 1'b0, 1'b0);
      b_wr = n_wr; b_evf = n_evf; b_evb = n_evb;
      send_frame(10, 0);
      chk_bd("R6 R5 fill bd0", 0, 0, 5'b10000, 4);
      chk_bd("R6 fill bd1", 1, 0, 5'b00000, 4);
      chk_bd("R6 R4 fill bd2 last", 2, 0, 5'b01000, 10);
      chk("R3 R6 spill writes", n_wr - b_wr, 10);
      chk("R6 spill last addr", last_addr, 2 * 16 + 1);
      chk("R11 buf event only for bd0", n_evb - b_evb, 1);
      chk("R4 spill frame event", n_evf - b_evf, 1);
      // R6: exact fill stays in one descriptor
      b_evb = n_evb;
      send_frame(4, 0);
      chk_bd("R6 exact fill bd3", 3, 0, 5'b11000, 4);
      chk_bd("R6 exact fill bd4 untouched", 4, 0, 0, 0);
      chk("R6 exact fill no buf event", n_evb - b_evb, 0);

      // R10: wrap returns to descriptor 0
      do_reset();
      max_len = 12'd10; buf_size = 5'd16;
      arm(0, 1'b1, 1'b0); arm(1, 1'b0, 1'b0);
      send_frame(2, 0);
      arm(0, 1'b1, 1'b0);
      b_evy = n_evy;
      send_frame(3, 0);
      chk("R10 wrap addr", last_addr, 2);
      chk_bd("R10 wrap bd0", 0, 0, 5'b11000, 3);
      chk_bd("R10 bd1 unused", 1, 1, 0, 0);
      chk("R10 no busy", n_evy - b_evy, 0);

      // R12: busy and discard
      do_reset();
      b_wr = n_wr; b_evf = n_evf; b_evy = n_evy;
      send_frame(3, 0);
      chk("R12 single busy pulse", n_evy - b_evy, 1);
      chk("R12 no writes", n_wr - b_wr, 0);
      chk("R12 no frame event", n_evf - b_evf, 0);
      chk_bd("R12 bd0 unchanged", 0, 0, 0, 0);
      arm(0, 1'b0, 1'b0);
      send_frame(1, 0);
      chk("R12 recover addr", last_addr, 0);
      chk_bd("R12 recover bd0", 0, 0, 5'b11000, 1);

      // R9: abort in frame, idle ones, broken run
      do_reset();
      arm(0, 1'b0, 1'b1); arm(1, 1'b0, 1'b1);
      b_evf = n_evf; b_evb = n_evb;
      send_oct(8'h11); send_oct(8'h22);
      send_bits(7, 1'b1);
      repeat (2) @(negedge clk);
      chk_bd("R9 abort bd0", 0, 0, 5'b11001, 2);
      chk("R9 R11 abort buf event", n_evb - b_evb, 1);
      chk("R9 abort no frame event", n_evf - b_evf, 0);
      send_bits(8, 1'b1);
      send_bits(1, 1'b0);
      repeat (2) @(negedge clk);
      chk_bd("R9 idle ones bd1", 1, 1, 0, 0);
      chk("R9 idle ones no event", n_evb - b_evb, 1);
      send_oct(8'h33);
      send_bits(6, 1'b1); send_bits(1, 1'b0); send_bits(6, 1'b1);
      send_oct(8'h44);
      send_flag(0);
      repeat (2) @(negedge clk);
      chk_bd("R9 broken run bd1", 1, 0, 5'b11000, 2);

      // R4: octet with flag in the same cycle is dropped
      do_reset();
      arm(0, 1'b0, 1'b0);
      b_wr = n_wr; b_evf = n_evf;
      send_oct(8'h55); send_oct(8'h66);
      oct_valid = 1'b1; oct_data = 8'h77; flag_close = 1'b1;
      @(negedge clk);
      oct_valid = 1'b0; flag_close = 1'b0;
      repeat (2) @(negedge clk);
      chk("R4 same-cycle writes", n_wr - b_wr, 2);
      chk("R4 same-cycle frame event", n_evf - b_evf, 1);
      chk_bd("R4 same-cycle bd0", 0, 0, 5'b11000, 2);
      idx = 0; st = 0;

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad);
      $finish;
   end
endmodule